// File: doc/BRIEF.md
# Sequential Block-Write Configuration Register Slave

This block is a two-wire serial bus slave that owns a bank of 8-bit configuration registers and presents every register in parallel to the surrounding logic. It supports block writes only. After its write address, the host sends two header bytes, a command code and a byte count. The slave acknowledges both and then discards them. Each data byte that follows lands in the next register, starting at register 0, until the host ends the transfer. Nothing in the bus protocol selects a register; the position of a byte in the transfer decides where it goes.

A read transfer returns a length byte first, then registers from 0 upward. The length byte is the content of a dedicated count register, and that register also sets how many registers carry real data. Two register pairs are written atomically: the first byte of a pair is staged, and both bytes reach the bank only when the second byte arrives in the same transfer.

The clock and data lines are oversampled by the system clock through two-flop synchronizers. The slave only ever pulls the data line low, through an open-drain enable. It never stretches the clock, so SCL is an input only. Each SCL high phase and each SCL low phase must last at least 6 system clock cycles. At a bus rate of 100 kbit/s or lower, this holds with any system clock above about 1.2 MHz. The bank has no data stream with back-pressure: the register outputs are plain levels, and the serial bus paces every transfer.

Top module: `cfg_serial_slave`

## Requirements
- R1: At reset, every register holds 0x00 except the count register (index 8), which holds 0x08, and the data line is released.
- R2: The slave acknowledges (pulls SDA low in the ninth clock) the address byte 0xD2 for writes and 0xD3 for reads. For any other address byte it does not acknowledge, and it ignores the rest of that transfer.
- R3: In a write, the first two bytes after the address are acknowledged and discarded. Data byte k (k = 0, 1, 2, …) goes to register k.
- R4: A stop after any complete acknowledged byte keeps every byte completed so far. A byte cut short by a stop is discarded.
- R5: Registers 11/12 and 13/14 form pairs. A transfer that delivers only the lower byte of a pair changes neither register of that pair. A transfer that delivers both bytes updates both in the same clock cycle.
- R6: A read returns the count register value first, then register 0, register 1, and so on, with MSB first on the wire.
- R7: Read byte position k+1 returns 0x00 when k is at least the count register value or at least the number of registers (17).
- R8: When the host does not acknowledge a read byte, the slave releases SDA and sends nothing more until the next start.
- R9: Data bytes past the last register are acknowledged and discarded. They do not wrap onto lower registers.
- R10: A repeated start ends the current transfer, drops any staged pair byte, and begins a new address phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired-AND of all drivers) |
| sda_drive_low | output | 1 | When 1, the open-drain driver pulls SDA low |
| cfg_regs | output | NUM_REGS*8 (136) | Register bank, register i on bits [8i+7:8i] |

## Verification
The hardest condition to reach from the pins is a pair whose lower byte is staged when the transfer ends. Addressing is strictly sequential, so the only way to get there is a block write of exactly 12 or exactly 14 data bytes, closed by either a stop or a repeated start. The stimulus runs both lengths and both ways of ending the transfer, then reads the bank through the pins and through a serial read. A stop placed in the middle of a byte and a write that overruns the bank cover the other edges of the sequential write index.

// File: rtl/cfgs_pkg.sv
package cfgs_pkg;

  typedef enum logic [2:0] {
    L_IDLE,
    L_ADDR,
    L_ADDR_ACK,
    L_WR_BYTE,
    L_WR_ACK,
    L_RD_BYTE,
    L_RD_ACK
  } link_state_t;

  function automatic logic [7:0] reg_reset_value(input int idx, input int cnt_idx,
                                                 input logic [7:0] cnt_dflt);
    return (idx == cnt_idx) ? cnt_dflt : 8'h00;
  endfunction

endpackage

// File: rtl/cfgs_bus_sense.sv
module cfgs_bus_sense #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  logic [SYNC_STAGES-1:0] scl_sync, sda_sync;
  logic scl_s, scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync <= '1;
      sda_sync <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
      sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
      scl_q    <= scl_s;
      sda_q    <= sda_s;
    end
  end

  assign scl_s     = scl_sync[SYNC_STAGES-1];
  assign sda_s     = sda_sync[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/cfgs_bank.sv
module cfgs_bank
  import cfgs_pkg::*;
#(
  parameter int         NUM_REGS      = 17,
  parameter int         COUNT_IDX     = 8,
  parameter logic [7:0] COUNT_DEFAULT = 8'h08,
  parameter int         NUM_PAIRS     = 2,
  parameter int         PAIR_LO [NUM_PAIRS] = '{11, 13},
  parameter int         IDX_W         = 9
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [7:0]            wr_data,
  input  logic                  xfer_end,
  input  logic [IDX_W-1:0]      rd_idx,
  output logic [7:0]            rd_data,
  output logic [7:0]            count_val,
  output logic [NUM_REGS*8-1:0] regs_flat
);

  logic [7:0]           regs_q [NUM_REGS];
  logic [7:0]           pend_q [NUM_PAIRS];
  logic [NUM_PAIRS-1:0] pend_vld;

  function automatic logic pair_member(input int i);
    for (int p = 0; p < NUM_PAIRS; p++)
      if (i == PAIR_LO[p] || i == PAIR_LO[p] + 1) return 1'b1;
    return 1'b0;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++)
        regs_q[i] <= reg_reset_value(i, COUNT_IDX, COUNT_DEFAULT);
      for (int p = 0; p < NUM_PAIRS; p++) pend_q[p] <= 8'h00;
      pend_vld <= '0;
    end else begin
      for (int i = 0; i < NUM_REGS; i++)
        if (wr_en && wr_idx == IDX_W'(i) && !pair_member(i)) regs_q[i] <= wr_data;
      for (int p = 0; p < NUM_PAIRS; p++) begin
        if (xfer_end) begin
          pend_vld[p] <= 1'b0;
        end else if (wr_en && wr_idx == IDX_W'(PAIR_LO[p])) begin
          pend_q[p]   <= wr_data;
          pend_vld[p] <= 1'b1;
        end else if (wr_en && wr_idx == IDX_W'(PAIR_LO[p] + 1) && pend_vld[p]) begin
          if (PAIR_LO[p] + 1 < NUM_REGS) begin
            regs_q[PAIR_LO[p]]     <= pend_q[p];
            regs_q[PAIR_LO[p] + 1] <= wr_data;
          end
          pend_vld[p] <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    rd_data = 8'h00;
    for (int i = 0; i < NUM_REGS; i++)
      if (rd_idx == IDX_W'(i)) rd_data = regs_q[i];
  end

  assign count_val = regs_q[COUNT_IDX];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
    assign regs_flat[g*8 +: 8] = regs_q[g];
  end

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair_chk
    AST_PAIR_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(regs_q[PAIR_LO[p]]) || !$stable(regs_q[PAIR_LO[p] + 1])) |->
        ($past(wr_en) && $past(wr_idx) == IDX_W'(PAIR_LO[p] + 1) && $past(pend_vld[p]))); // R5
  end

  AST_OOR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx >= IDX_W'(NUM_REGS)) |=> $stable(regs_flat)); // R9

endmodule

// File: rtl/cfgs_link.sv
module cfgs_link
  import cfgs_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int         IDX_W    = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sda_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_evt,
  input  logic             stop_evt,
  input  logic [7:0]       rd_data,
  input  logic [7:0]       rd_limit,
  output logic [IDX_W-1:0] rd_idx,
  output logic             sda_oe,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [7:0]       wr_data,
  output logic             xfer_end
);

  link_state_t      state;
  logic [3:0]       bitcnt;
  logic [7:0]       shreg;
  logic [IDX_W-1:0] byte_cnt;
  logic             is_read;
  logic             host_ack;
  logic [7:0]       tx_next;

  assign rd_idx = byte_cnt - IDX_W'(1);

  always_comb begin
    if (byte_cnt == '0)                         tx_next = rd_limit;
    else if (rd_idx < {{(IDX_W-8){1'b0}}, rd_limit}) tx_next = rd_data;
    else                                        tx_next = 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= L_IDLE;
      bitcnt   <= '0;
      shreg    <= '0;
      byte_cnt <= '0;
      is_read  <= 1'b0;
      host_ack <= 1'b0;
      sda_oe   <= 1'b0;
      wr_en    <= 1'b0;
      wr_idx   <= '0;
      wr_data  <= '0;
      xfer_end <= 1'b0;
    end else begin
      wr_en    <= 1'b0;
      xfer_end <= 1'b0;
      if (start_evt) begin
        state    <= L_ADDR;
        bitcnt   <= '0;
        byte_cnt <= '0;
        sda_oe   <= 1'b0;
        xfer_end <= 1'b1;
      end else if (stop_evt) begin
        state    <= L_IDLE;
        sda_oe   <= 1'b0;
        xfer_end <= 1'b1;
      end else begin
        unique case (state)
          L_ADDR, L_WR_BYTE: begin
            if (scl_rise) begin
              shreg  <= {shreg[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              if (state == L_ADDR) begin
                if (shreg[7:1] == DEV_ADDR) begin
                  sda_oe  <= 1'b1;
                  is_read <= shreg[0];
                  state   <= L_ADDR_ACK;
                end else begin
                  state <= L_IDLE;
                end
              end else begin
                sda_oe <= 1'b1;
                state  <= L_WR_ACK;
                if (byte_cnt >= IDX_W'(2)) begin
                  wr_en   <= 1'b1;
                  wr_idx  <= byte_cnt - IDX_W'(2);
                  wr_data <= shreg;
                end
                if (byte_cnt != '1) byte_cnt <= byte_cnt + IDX_W'(1);
              end
            end
          end
          L_ADDR_ACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (is_read) begin
                shreg  <= tx_next;
                sda_oe <= ~tx_next[7];
                state  <= L_RD_BYTE;
              end else begin
                sda_oe <= 1'b0;
                state  <= L_WR_BYTE;
              end
            end
          end
          L_WR_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              bitcnt <= '0;
              state  <= L_WR_BYTE;
            end
          end
          L_RD_BYTE: begin
            if (scl_fall) begin
              if (bitcnt == 4'd7) begin
                sda_oe <= 1'b0;
                state  <= L_RD_ACK;
                if (byte_cnt != '1) byte_cnt <= byte_cnt + IDX_W'(1);
              end else begin
                sda_oe <= ~shreg[6];
                shreg  <= {shreg[6:0], 1'b0};
                bitcnt <= bitcnt + 4'd1;
              end
            end
          end
          L_RD_ACK: begin
            if (scl_rise) begin
              host_ack <= ~sda_s;
            end else if (scl_fall) begin
              if (host_ack) begin
                shreg  <= tx_next;
                sda_oe <= ~tx_next[7];
                bitcnt <= '0;
                state  <= L_RD_BYTE;
              end else begin
                state <= L_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == L_IDLE) |-> !sda_oe); // R8
  AST_ADDR_ACK_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (state == L_ADDR_ACK) |-> sda_oe); // R2
  AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (state == L_ADDR && !sda_oe && xfer_end)); // R10
  AST_HEADER_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == L_WR_BYTE && scl_fall && bitcnt == 4'd8 && byte_cnt < IDX_W'(2)) |=> !wr_en); // R3

endmodule

// File: rtl/cfg_serial_slave.sv
module cfg_serial_slave #(
  parameter int         NUM_REGS      = 17,
  parameter int         COUNT_IDX     = 8,
  parameter logic [7:0] COUNT_DEFAULT = 8'h08,
  parameter logic [6:0] DEV_ADDR      = 7'h69,
  parameter int         SYNC_STAGES   = 2,
  parameter int         NUM_PAIRS     = 2,
  parameter int         PAIR_LO [NUM_PAIRS] = '{11, 13}
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_drive_low,
  output logic [NUM_REGS*8-1:0] cfg_regs
);

  localparam int IDX_W = 9;

  logic             sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic             wr_en, xfer_end;
  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic [7:0]       wr_data, rd_data, count_val;

  cfgs_bus_sense #(.SYNC_STAGES(SYNC_STAGES)) i_sense (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  cfgs_link #(.DEV_ADDR(DEV_ADDR), .IDX_W(IDX_W)) i_link (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt),
    .rd_data(rd_data), .rd_limit(count_val), .rd_idx(rd_idx),
    .sda_oe(sda_drive_low), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .xfer_end(xfer_end)
  );

  cfgs_bank #(
    .NUM_REGS(NUM_REGS), .COUNT_IDX(COUNT_IDX), .COUNT_DEFAULT(COUNT_DEFAULT),
    .NUM_PAIRS(NUM_PAIRS), .PAIR_LO(PAIR_LO), .IDX_W(IDX_W)
  ) i_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .xfer_end(xfer_end), .rd_idx(rd_idx),
    .rd_data(rd_data), .count_val(count_val), .regs_flat(cfg_regs)
  );

endmodule

// File: tb/test_cfg_serial_slave.sv
module test_cfg_serial_slave;

  localparam int CLK_PERIOD = 10;
  localparam int H          = 8;
  localparam int NREGS      = 17;

  localparam logic [31:0] VEC [6] = '{
    32'h01_02_03_04, 32'hFF_00_FF_00, 32'hA5_5A_C3_3C,
    32'h80_7F_01_FE, 32'h00_00_00_00, 32'h12_34_56_78
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic host_sda = 1'b1;
  logic sda_drive_low;
  logic [NREGS*8-1:0] cfg_regs;
  wire  sda_line = host_sda & ~sda_drive_low;

  int n_checks = 0;
  int n_fails  = 0;
  logic [7:0] exp_regs [NREGS];
  logic [7:0] wbuf [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_serial_slave i_cfg_serial_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_drive_low(sda_drive_low), .cfg_regs(cfg_regs)
  );

  task automatic wcyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_regs(input string req);
    logic [NREGS*8-1:0] flat;
    for (int i = 0; i < NREGS; i++) flat[i*8 +: 8] = exp_regs[i];
    chk(req, 256'(cfg_regs), 256'(flat));
  endtask

  task automatic bus_start();
    wcyc(2); host_sda = 1'b1; wcyc(H); scl = 1'b1; wcyc(H);
    host_sda = 1'b0; wcyc(H); scl = 1'b0;
  endtask

  task automatic bus_stop();
    wcyc(2); host_sda = 1'b0; wcyc(H); scl = 1'b1; wcyc(H);
    host_sda = 1'b1; wcyc(H);
  endtask

  task automatic bit_out(input logic b);
    wcyc(2); host_sda = b; wcyc(H); scl = 1'b1; wcyc(H); scl = 1'b0;
  endtask

  task automatic bit_in(output logic b);
    wcyc(2); host_sda = 1'b1; wcyc(H); scl = 1'b1; wcyc(H/2);
    b = sda_line; wcyc(H - H/2); scl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack_n);
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    bit_in(ack_n);
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin bit_in(b); d[i] = b; end
    bit_out(~give_ack);
  endtask

  // Bench model of a block write of n data bytes closed after a full byte
  task automatic model_write(input int n);
    for (int i = 0; i < n && i < NREGS; i++) begin
      if ((i == 11 || i == 12) && n < 13) continue;
      if ((i == 13 || i == 14) && n < 15) continue;
      exp_regs[i] = wbuf[i];
    end
  endtask

  function automatic logic [7:0] exp_read(input int k);
    if (k == 0) return exp_regs[8];
    if ((k - 1) < int'(exp_regs[8]) && (k - 1) < NREGS) return exp_regs[k-1];
    return 8'h00;
  endfunction

  task automatic blk_write(input int n, input bit restart, input string req);
    logic a; logic any_nack = 1'b0;
    bus_start();
    send_byte(8'hD2, a); chk("R2 write address ack", 256'(a), 256'(0));
    send_byte(8'hA5, a); any_nack |= a;
    send_byte(8'h3C, a); any_nack |= a;
    for (int i = 0; i < n; i++) begin send_byte(wbuf[i], a); any_nack |= a; end
    chk(req, 256'(any_nack), 256'(0));
    if (!restart) bus_stop();
    model_write(n);
  endtask

  task automatic blk_read(input int n, input string req);
    logic a; logic [7:0] d;
    bus_start();
    send_byte(8'hD3, a); chk("R2 read address ack", 256'(a), 256'(0));
    for (int k = 0; k <= n; k++) begin
      recv_byte(k != n, d);
      chk(req, 256'(d), 256'(exp_read(k)));
    end
    wcyc(H);
    chk("R8 released after host NACK", 256'(sda_drive_low), 256'(0));
    bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    logic a;
    for (int i = 0; i < NREGS; i++) exp_regs[i] = (i == 8) ? 8'h08 : 8'h00;
    wcyc(5); rst_n = 1'b1; wcyc(5);

    // R1 reset state
    chk_regs("R1 reset defaults");
    chk("R1 sda released at reset", 256'(sda_drive_low), 256'(0));

    // R3 and R6: vector table, write four bytes then read them back
    for (int v = 0; v < 6; v++) begin
      for (int b = 0; b < 4; b++) wbuf[b] = VEC[v][31 - 8*b -: 8];
      blk_write(4, 1'b0, "R3 data acks");
      chk_regs("R3 sequential placement");
      blk_read(5, "R6 readback order");
    end

    // R2 foreign address is ignored
    bus_start();
    send_byte(8'hA0, a); chk("R2 foreign address not acked", 256'(a), 256'(1));
    send_byte(8'h11, a); send_byte(8'h22, a); send_byte(8'h33, a);
    bus_stop();
    chk_regs("R2 foreign transfer ignored");

    // R5 pair half pending at stop: 12 bytes
    for (int i = 0; i < 32; i++) wbuf[i] = 8'h40 + 8'(i);
    wbuf[8] = 8'h08;
    blk_write(12, 1'b0, "R4 acks");
    chk_regs("R5 lone pair byte dropped, R4 earlier bytes kept");
    chk("R5 reg11 unchanged", 256'(cfg_regs[11*8 +: 8]), 256'(0));
    blk_write(13, 1'b0, "R5 acks");
    chk_regs("R5 pair 11/12 committed");
    for (int i = 0; i < 32; i++) wbuf[i] = 8'h90 + 8'(i);
    wbuf[8] = 8'h08;
    blk_write(14, 1'b0, "R5 acks");
    chk_regs("R5 pair 13/14 half dropped");

    // R4 stop inside a byte
    for (int i = 0; i < 32; i++) wbuf[i] = 8'hC0 + 8'(i);
    bus_start();
    send_byte(8'hD2, a); send_byte(8'h00, a); send_byte(8'h00, a);
    send_byte(wbuf[0], a); send_byte(wbuf[1], a);
    bit_out(1'b1); bit_out(1'b0); bit_out(1'b1); bit_out(1'b1);
    bus_stop();
    model_write(2);
    chk_regs("R4 partial byte discarded");

    // R10 repeated start with staged pair byte
    for (int i = 0; i < 32; i++) wbuf[i] = 8'h20 + 8'(i);
    wbuf[8] = 8'h08;
    blk_write(12, 1'b1, "R10 acks");
    blk_read(13, "R10 read after repeated start");
    chk_regs("R10 staged byte dropped");

    // R9 overrun past last register
    for (int i = 0; i < 32; i++) wbuf[i] = 8'hE0 + 8'(i);
    wbuf[8] = 8'h08;
    blk_write(20, 1'b0, "R9 overrun bytes acked");
    chk_regs("R9 overrun discarded");

    // R7 short count then long count
    wbuf[8] = 8'h03;
    blk_write(9, 1'b0, "R7 acks");
    chk_regs("R7 count register written");
    blk_read(6, "R7 bytes past count read zero");
    wbuf[8] = 8'd20;
    blk_write(9, 1'b0, "R7 acks");
    blk_read(21, "R7 bytes past bank read zero");

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule